// File: doc/BRIEF.md
# External Reset Pulse Generator

This block turns a single-cycle timeout trigger into a timed reset pulse on an external pin. It holds one configuration register on a simple write bus. The register sets three things: how many microsecond ticks the pulse lasts, which level counts as asserted, and whether the pin is driven both ways or only pulled toward its active level. A free-running 1 MHz tick enable paces the pulse. The logic that produces the trigger and the pad cell itself both sit outside the block.

The pin is presented as a data/output-enable pair, so the same logic can drive a push-pull pad or emulate an open-drain one. Polarity and drive mode are guarded against accidental change. Only four reserved values in the top byte of a register write can alter them. Every write to the register still updates the duration field, whatever the top byte holds. A build parameter selects a narrow variant whose duration field is 8 bits instead of 20.

Top module: `extPulseGen`

## Requirements
- R1: After reset, the duration field holds 0xFF and the output is active-low and open-drain. Read data at offset 0x18 is 0x000000FF, padOe is 0 and padOut is 1.
- R2: Every write to offset 0x18 replaces the duration field (bits 19:0) with the written bits. Register bits 29:20 read as 0. A write to any other offset changes nothing.
- R3: A trigger received while idle asserts the output on the next clock. The output stays asserted for exactly (duration + 1) tick pulses and is released on the clock edge of the last of them.
- R4: A write whose bits 31:24 equal 0xA5 makes the output active-high. A write whose bits 31:24 equal 0x5A makes it active-low.
- R5: A write whose bits 31:24 equal 0xA8 selects push-pull drive. A write whose bits 31:24 equal 0x8A selects open-drain drive.
- R6: Any other value in bits 31:24 leaves polarity and drive mode unchanged, while the duration field is still written.
- R7: Read data bit 31 is 1 when the output is active-high, and bit 30 is 1 when the drive is push-pull.
- R8: A trigger that arrives while a pulse is running is ignored. This includes a trigger arriving on the tick that ends the pulse. The pulse length is unchanged and no second pulse follows.
- R9: In open-drain mode, padOe is 1 only while the pulse is asserted, and padOut then carries the active level.
- R10: In push-pull mode, padOe is always 1. padOut carries the active level during the pulse and the inactive level otherwise.
- R11: When a register write and a trigger land in the same cycle, the pulse uses the duration held before that write. The written value governs later pulses.
- R12: With NARROW set, the duration field is bits 7:0 only. Bits 29:8 read as 0, and the pulse lasts (bits 7:0 + 1) ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Byte offset for write and read |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Register contents when busAddr is 0x18, else 0 |
| tick | input | 1 | One-cycle 1 MHz tick enable |
| trigger | input | 1 | Timeout trigger that starts a pulse |
| padOut | output | 1 | Pin data level |
| padOe | output | 1 | Pin output enable |

## Verification
Two pairs of events can share a cycle. The first pair is a register write and a trigger: the bench raises both on the same edge and expects the pulse to count the duration held before the write. The second pair is the tick that ends a pulse and a fresh trigger: the bench raises the trigger on exactly that tick and expects the output to fall with no second pulse. Pulse lengths are judged by counting the ticks the bench issues while it sees the pin asserted. All 256 top-byte values are swept from each of the four polarity and drive states, and the resulting read data is compared against an arithmetic model.

// File: rtl/extPulsePkg.sv
package extPulsePkg;

  typedef struct packed {
    logic load;
    logic dec;
  } pulseStrobe_t;

  localparam logic [7:0] KEY_ACT_HIGH   = 8'hA5;
  localparam logic [7:0] KEY_ACT_LOW    = 8'h5A;
  localparam logic [7:0] KEY_PUSH_PULL  = 8'hA8;
  localparam logic [7:0] KEY_OPEN_DRAIN = 8'h8A;

  localparam int REG_W = 32;
  localparam int FLAG_W = 2;

endpackage

// File: rtl/extPulseDatapath.sv
module extPulseDatapath
  import extPulsePkg::*;
#(
  parameter int DUR_W = 20,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CFG_OFFSET = ADDR_W'('h18)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [REG_W-1:0]   busWrData,
  input  pulseStrobe_t       strobe,
  output logic [REG_W-1:0]   busRdData,
  output logic               actHigh,
  output logic               pushPull,
  output logic               cntZero
);

  localparam int PAD_W = REG_W - FLAG_W - DUR_W;
  localparam logic [DUR_W-1:0] DUR_RESET = DUR_W'(255);

  logic [DUR_W-1:0] durReg;
  logic [DUR_W-1:0] cnt;
  logic [REG_W-1:0] rdWord;
  logic             cfgWr;
  logic [7:0]       keyByte;

  assign cfgWr   = busWrEn && (busAddr == CFG_OFFSET);
  assign keyByte = busWrData[REG_W-1 -: 8];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      durReg   <= DUR_RESET;
      actHigh  <= 1'b0;
      pushPull <= 1'b0;
    end else if (cfgWr) begin
      durReg <= busWrData[DUR_W-1:0];
      case (keyByte)
        KEY_ACT_HIGH:   actHigh  <= 1'b1;
        KEY_ACT_LOW:    actHigh  <= 1'b0;
        KEY_PUSH_PULL:  pushPull <= 1'b1;
        KEY_OPEN_DRAIN: pushPull <= 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.load) begin
      cnt <= durReg;
    end else if (strobe.dec) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntZero = (cnt == '0);

  generate
    if (PAD_W > 0) begin : g_padded
      assign rdWord = {actHigh, pushPull, {PAD_W{1'b0}}, durReg};
    end else begin : g_full
      assign rdWord = {actHigh, pushPull, durReg};
    end
  endgenerate

  assign busRdData = (busAddr == CFG_OFFSET) ? rdWord : '0;

  // R2: the duration field takes the written bits
  a_r2_dur_written: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr |=> durReg == $past(busWrData[DUR_W-1:0]));

  // R4: the high-polarity key sets active-high
  a_r4_key_high: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && keyByte == KEY_ACT_HIGH) |=> actHigh);

  // R5: the open-drain key clears push-pull
  a_r5_key_od: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && keyByte == KEY_OPEN_DRAIN) |=> !pushPull);

  // R6: other top bytes leave the mode flags alone
  a_r6_other_key: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && keyByte != KEY_ACT_HIGH && keyByte != KEY_ACT_LOW &&
     keyByte != KEY_PUSH_PULL && keyByte != KEY_OPEN_DRAIN)
    |=> $stable(actHigh) && $stable(pushPull));

  // R3: each decrement lowers the count by one
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dec |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/extPulseCtrl.sv
module extPulseCtrl
  import extPulsePkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         trigger,
  input  logic         tick,
  input  logic         cntZero,
  input  logic         actHigh,
  input  logic         pushPull,
  output pulseStrobe_t strobe,
  output logic         padOut,
  output logic         padOe
);

  logic active;
  logic endTick;

  always_comb begin
    strobe.load = trigger && !active;
    strobe.dec  = active && tick && !cntZero;
    endTick     = active && tick && cntZero;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
    end else if (strobe.load) begin
      active <= 1'b1;
    end else if (endTick) begin
      active <= 1'b0;
    end
  end

  assign padOut = active ? actHigh : !actHigh;
  assign padOe  = pushPull || active;

  // R3: a pulse only starts from a trigger
  a_r3_start_from_trigger: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> $past(trigger));

  // R3: a pulse only ends on a tick with the count exhausted
  a_r3_end_on_last_tick: assert property (@(posedge clk) disable iff (!rstN)
    $fell(active) |-> $past(tick && cntZero));

  // R8: a running pulse holds until its last tick, triggers notwithstanding
  a_r8_hold_while_running: assert property (@(posedge clk) disable iff (!rstN)
    (active && !(tick && cntZero)) |=> active);

endmodule

// File: rtl/extPulseGen.sv
module extPulseGen
  import extPulsePkg::*;
#(
  parameter bit NARROW = 1'b0,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CFG_OFFSET = ADDR_W'('h18)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic              tick,
  input  logic              trigger,
  output logic              padOut,
  output logic              padOe
);

  localparam int DUR_W = NARROW ? 8 : 20;

  pulseStrobe_t strobe;
  logic actHigh;
  logic pushPull;
  logic cntZero;

  extPulseDatapath #(
    .DUR_W(DUR_W),
    .ADDR_W(ADDR_W),
    .CFG_OFFSET(CFG_OFFSET)
  ) u_datapath (
    .clk(clk),
    .rstN(rstN),
    .busWrEn(busWrEn),
    .busAddr(busAddr),
    .busWrData(busWrData),
    .strobe(strobe),
    .busRdData(busRdData),
    .actHigh(actHigh),
    .pushPull(pushPull),
    .cntZero(cntZero)
  );

  extPulseCtrl u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .trigger(trigger),
    .tick(tick),
    .cntZero(cntZero),
    .actHigh(actHigh),
    .pushPull(pushPull),
    .strobe(strobe),
    .padOut(padOut),
    .padOe(padOe)
  );

endmodule

// File: tb/extPulseGen_bench.sv
module extPulseGen_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] CFG = 8'h18;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic [7:0] busAddr = CFG;
  logic [31:0] busWrData = '0;
  logic tick = 1'b0;
  logic trigger = 1'b0;
  logic [31:0] busRdData, nRdData;
  logic padOut, padOe, nPadOut, nPadOe;

  int checkCnt = 0;
  int failCnt = 0;

  logic [19:0] expDur = 20'hFF;
  logic expHigh = 1'b0;
  logic expPP = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  extPulseGen u_extPulseGen (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .tick(tick),
    .trigger(trigger), .padOut(padOut), .padOe(padOe)
  );

  extPulseGen #(.NARROW(1'b1)) u_extPulseGenNarrow (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(nRdData), .tick(tick),
    .trigger(trigger), .padOut(nPadOut), .padOe(nPadOe)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic applyModel(input logic [31:0] d);
    expDur = d[19:0];
    case (d[31:24])
      8'hA5: expHigh = 1'b1;
      8'h5A: expHigh = 1'b0;
      8'hA8: expPP = 1'b1;
      8'h8A: expPP = 1'b0;
      default: ;
    endcase
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = CFG;
    if (a == CFG) applyModel(d);
  endtask

  task automatic setMode(input bit h, input bit p);
    doWrite(CFG, {h ? 8'hA5 : 8'h5A, 4'h0, expDur});
    doWrite(CFG, {p ? 8'hA8 : 8'h8A, 4'h0, expDur});
  endtask

  task automatic checkRead(input string tag);
    logic [31:0] ew, en;
    busAddr = CFG;
    #1;
    ew = {expHigh, expPP, 10'b0, expDur};
    en = {expHigh, expPP, 22'b0, expDur[7:0]};
    check(busRdData == ew, tag, busRdData, ew);
    check(nRdData == en, {tag, " R12 narrow"}, nRdData, en);
  endtask

  task automatic checkIdle(input string tag);
    #1;
    if (expPP) begin
      check(padOe && padOut == !expHigh, {tag, " R10 idle"}, {padOe, padOut}, {1'b1, !expHigh});
      check(nPadOe && nPadOut == !expHigh, {tag, " R10 idle narrow"}, {nPadOe, nPadOut}, {1'b1, !expHigh});
    end else begin
      check(!padOe, {tag, " R9 idle"}, padOe, 0);
      check(!nPadOe, {tag, " R9 idle narrow"}, nPadOe, 0);
    end
  endtask

  // Trigger a pulse and count ticks issued while each output is asserted.
  task automatic runPulse(input int div, input int retrigAt, input bit doWr,
                          input logic [31:0] wv, input int expW, input int expN,
                          input string tag);
    int cntW = 0, cntN = 0, shapeBad = 0;
    bit aW, aN;
    @(negedge clk);
    trigger = 1'b1; tick = 1'b0;
    if (doWr) begin busWrEn = 1'b1; busAddr = CFG; busWrData = wv; end
    for (int i = 1; i < 5000; i++) begin
      @(negedge clk);
      trigger = 1'b0;
      if (i == 1 && doWr) begin busWrEn = 1'b0; applyModel(wv); end
      if (expPP) begin
        aW = (padOut == expHigh); aN = (nPadOut == expHigh);
        if (!padOe || !nPadOe) shapeBad++;
      end else begin
        aW = padOe; aN = nPadOe;
        if ((padOe && padOut != expHigh) || (nPadOe && nPadOut != expHigh)) shapeBad++;
      end
      if (!aW && !aN) break;
      tick = ((i % div) == 0);
      if (aW && tick) cntW++;
      if (aN && tick) cntN++;
      trigger = (i == retrigAt);
    end
    tick = 1'b0; trigger = 1'b0;
    check(cntW == expW, {tag, " ticks"}, cntW, expW);
    check(cntN == expN, {tag, " ticks narrow"}, cntN, expN);
    check(shapeBad == 0, {tag, expPP ? " R10 shape" : " R9 shape"}, shapeBad, 0);
    checkIdle(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checkCnt++; failCnt++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    checkRead("R1 reset read");
    check(!padOe && padOut, "R1 reset pins", {padOe, padOut}, 2'b01);
    check(!nPadOe && nPadOut, "R1 reset pins narrow", {nPadOe, nPadOut}, 2'b01);

    // R3 / R1: default duration gives 256 ticks
    runPulse(1, 0, 1'b0, '0, 256, 256, "R3 default");

    // R2: write to another offset changes nothing
    doWrite(8'h1C, 32'hA5A8_0010);
    checkRead("R2 other offset");

    // R4 R5 R6 R7 R2 R12: sweep all top bytes from every mode state
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 256; v++) begin
        logic [31:0] d;
        setMode(s[0], s[1]);
        d = {v[7:0], 24'(v * 4099 + s * 77 + 5)};
        doWrite(CFG, d);
        checkRead("R4 R5 R6 R7 key sweep");
      end
    end

    // R3 R9 R10: duration sweep, every-cycle tick, each mode
    for (int s = 0; s < 4; s++) begin
      setMode(s[0], s[1]);
      for (int d = 0; d < 12; d++) begin
        doWrite(CFG, 32'(d));
        runPulse(1, 0, 1'b0, '0, d + 1, d + 1, "R3 sweep div1");
      end
      for (int d = 0; d < 6; d++) begin
        doWrite(CFG, 32'(d));
        runPulse(3, 0, 1'b0, '0, d + 1, d + 1, "R3 sweep div3");
      end
    end

    // R12: duration bits above 7 ignored by the narrow variant
    setMode(1'b1, 1'b1);
    doWrite(CFG, 32'h0000_01FF);
    runPulse(1, 0, 1'b0, '0, 512, 256, "R12 wide 0x1FF");
    doWrite(CFG, 32'h0000_0100);
    runPulse(1, 0, 1'b0, '0, 257, 1, "R12 wide 0x100");

    // R8: retrigger early and on the final tick
    setMode(1'b0, 1'b0);
    doWrite(CFG, 32'd10);
    runPulse(1, 2, 1'b0, '0, 11, 11, "R8 retrigger mid");
    runPulse(1, 11, 1'b0, '0, 11, 11, "R8 retrigger on last tick");

    // R11: write and trigger in the same cycle
    setMode(1'b1, 1'b0);
    doWrite(CFG, 32'd6);
    runPulse(1, 0, 1'b1, 32'd40, 7, 7, "R11 old duration");
    runPulse(1, 0, 1'b0, '0, 41, 41, "R11 new duration");
    checkRead("R11 read after");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

endmodule